// File: doc/BRIEF.md
# CPU Bus Decoder and Transfer Sequencer

This block sits between a 16-bit processor core and everything it addresses. The core asks for one transfer at a time with a single-cycle start pulse. The pulse carries the address, the direction, the write data and a tag saying what kind of access it is. The block latches the request and decodes the 64K byte address space into one of four targets or an unmapped hole. It then runs a bus cycle with cycle, strobe, byte-select and active-low read/write strobes, and returns one completion pulse with the read data.

There are four targets: an internal 2 KB program ROM, an internal 2 KB data RAM, and two external devices. The first external device is the network controller, which occupies everything from 0x2000 upward. Internal targets and the unmapped hole finish in the first cycle of the transfer. External targets finish when the device acknowledges. If no acknowledge arrives, a counter ends the transfer after a set number of cycles. Toward the external devices the block owns a shared tri-state data bus. It drives that bus with the write data only while it is writing to an external device.

Top module: `cpu_bus_ctrl`

## Requirements
- R1: Decode map, byte addresses. ROM is 0x0000-0x07FF (`rom_cs`). Unmapped is 0x0800-0x0FFF. RAM is 0x1000-0x17FF (`ram_cs`). External device 1 is 0x1800-0x1FFF (`ext_cs_n[1]` low). External device 0 is 0x2000-0xFFFF (`ext_cs_n[0]` low). At most one select is active, and only while `cyc` is high. `ext_cs_n` bits idle high.
- R2: A completed read returns `rom_rdata` for ROM, `ram_rdata` for RAM, and 16'h0000 for an unmapped address.
- R3: A transfer to ROM, RAM or the unmapped hole has `cpu_done` high in its first active cycle, which is the cycle after the clock edge that accepted `cpu_req`. `cpu_done` is never high outside a cycle.
- R4: An external transfer ends in the first active cycle in which `ext_ack` is high. A read returns the value on `data_io` in that cycle.
- R5: With no acknowledge, an external transfer ends in its TIMEOUT_CYC-th active cycle, and a read returns 16'h0000. If `ext_ack` is high in that same last cycle, the acknowledge wins and the data from `data_io` is returned.
- R6: During a transfer, `cyc` and `stb` are high and `sel` is 2'b11. Exactly one of `rd_n`/`wr_n` is low: `rd_n` low for reads, `wr_n` low for writes. Both are never low together.
- R7: Kind encoding on `cpu_kind`: 0 is data load (`load_cyc`), 1 is instruction fetch (`fetch_cyc`), 2 is constant fetch (`const_cyc`), 3 is interrupt acknowledge (`inta_cyc`). Exactly the matching flag is high during the transfer.
- R8: `data_io` carries the write data during writes to an external device. In every other cycle it is released (high impedance), so an external device can drive read data onto it.
- R9: A `cpu_req` pulse that arrives while a transfer is in progress is ignored. After the current transfer completes, the bus returns to idle.
- R10: After reset the bus is idle. `cyc`, `stb`, `sel`, all flags, `rom_cs`, `ram_cs` and `cpu_done` are low, and `rd_n`, `wr_n` and `ext_cs_n` are high.
- R11: `bus_addr` shows the latched request address and `bus_wdata` shows the write data. Both stay unchanged for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle transfer start pulse |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_kind | input | 2 | Access kind tag (see R7) |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with cpu_done |
| cpu_done | output | 1 | Transfer completes this cycle |
| bus_addr | output | 16 | Latched address toward all targets |
| bus_wdata | output | 16 | Write data toward internal RAM |
| rom_cs | output | 1 | Internal ROM select |
| ram_cs | output | 1 | Internal RAM select |
| rom_rdata | input | 16 | ROM read word |
| ram_rdata | input | 16 | RAM read word |
| ext_cs_n | output | 2 | Active-low external device selects |
| ext_ack | input | 1 | External acknowledge |
| data_io | inout | 16 | Shared tri-state external data bus |
| cyc | output | 1 | Bus cycle in progress |
| stb | output | 1 | Valid transfer strobe |
| sel | output | 2 | Byte select |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| fetch_cyc | output | 1 | Instruction fetch tag |
| load_cyc | output | 1 | Data load tag |
| const_cyc | output | 1 | Constant fetch tag |
| inta_cyc | output | 1 | Interrupt acknowledge tag |

## Verification
The external acknowledge and the timeout expiry can land in the same cycle, and the block has to decide which one ends the transfer. The bench provokes this by having the stub device acknowledge in exactly the TIMEOUT_CYC-th active cycle. It judges the outcome on the completion cycle count and on whether the stub's word comes back instead of zero. A second clash is a new start pulse arriving mid-transfer. The bench injects one during a slow external access and checks that the bus stays idle after completion.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int EXT_N  = 2;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_FETCH = 2'd1,
        K_CONST = 2'd2,
        K_INTA  = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        RG_ROM  = 3'd0,
        RG_RAM  = 3'd1,
        RG_EXT0 = 3'd2,
        RG_EXT1 = 3'd3,
        RG_NONE = 3'd4
    } region_e;

    typedef struct packed {
        logic              we;
        cyc_kind_e         kind;
        region_e           rg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    function automatic logic is_ext(region_e r);
        return (r == RG_EXT0) || (r == RG_EXT1);
    endfunction

    function automatic region_e ext_region(int idx);
        return region_e'(3'(32'(RG_EXT0) + idx));
    endfunction

endpackage

// File: rtl/cbus_decode.sv
module cbus_decode
    import cbus_pkg::*;
#(
    parameter int ROM_BYTES  = 2048,
    parameter int RAM_BASE   = 32'h1000,
    parameter int RAM_BYTES  = 2048,
    parameter int EXT1_BASE  = 32'h1800,
    parameter int EXT1_BYTES = 2048,
    parameter int EXT0_BASE  = 32'h2000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rg
);
    localparam int RAM_END  = RAM_BASE + RAM_BYTES;
    localparam int EXT1_END = EXT1_BASE + EXT1_BYTES;

    logic [31:0] a;

    always_comb begin
        a = 32'(addr);
        if (a >= 32'(EXT0_BASE))
            rg = RG_EXT0;
        else if (a >= 32'(EXT1_BASE) && a < 32'(EXT1_END))
            rg = RG_EXT1;
        else if (a >= 32'(RAM_BASE) && a < 32'(RAM_END))
            rg = RG_RAM;
        else if (a < 32'(ROM_BYTES))
            rg = RG_ROM;
        else
            rg = RG_NONE;
    end

endmodule

// File: rtl/cbus_seq.sv
module cbus_seq
    import cbus_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  req,
    input  xfer_t nxt,
    input  logic  ext_ack,
    output logic  active,
    output xfer_t cur,
    output logic  done,
    output logic  timed_out
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT_CYC - 1);

    typedef enum logic {S_IDLE, S_ACTIVE} st_e;

    st_e              st;
    logic [CNT_W-1:0] tcnt;
    logic             ext;
    logic             last;

    assign active    = (st == S_ACTIVE);
    assign ext       = is_ext(cur.rg);
    assign last      = (tcnt == LIM);
    assign done      = active && (!ext || ext_ack || last);
    assign timed_out = active && ext && !ext_ack && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            cur  <= '0;
            tcnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req) begin
                        cur  <= nxt;
                        tcnt <= '0;
                        st   <= S_ACTIVE;
                    end
                end
                S_ACTIVE: begin
                    if (done) st <= S_IDLE;
                    else      tcnt <= tcnt + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cbus_rmux.sv
module cbus_rmux
    import cbus_pkg::*;
(
    input  logic              active,
    input  region_e           rg,
    input  logic              timed_out,
    input  logic [DATA_W-1:0] rom_d,
    input  logic [DATA_W-1:0] ram_d,
    input  logic [DATA_W-1:0] ext_d,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (active) begin
            case (rg)
                RG_ROM:           rdata = rom_d;
                RG_RAM:           rdata = ram_d;
                RG_EXT0, RG_EXT1: rdata = timed_out ? '0 : ext_d;
                default:          rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cpu_bus_ctrl.sv
module cpu_bus_ctrl
    import cbus_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_kind,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              rom_cs,
    output logic              ram_cs,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [EXT_N-1:0]  ext_cs_n,
    input  logic              ext_ack,
    inout  wire  [DATA_W-1:0] data_io,
    output logic              cyc,
    output logic              stb,
    output logic [1:0]        sel,
    output logic              rd_n,
    output logic              wr_n,
    output logic              fetch_cyc,
    output logic              load_cyc,
    output logic              const_cyc,
    output logic              inta_cyc
);
    region_e    dec_rg;
    xfer_t      nxt;
    xfer_t      cur;
    logic       active;
    logic       timed_out;
    logic       drive;
    logic [3:0] kind_vec;

    cbus_decode u_dec (
        .addr (cpu_addr),
        .rg   (dec_rg)
    );

    always_comb begin
        nxt.we    = cpu_we;
        nxt.kind  = cyc_kind_e'(cpu_kind);
        nxt.rg    = dec_rg;
        nxt.addr  = cpu_addr;
        nxt.wdata = cpu_wdata;
    end

    cbus_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (cpu_req),
        .nxt       (nxt),
        .ext_ack   (ext_ack),
        .active    (active),
        .cur       (cur),
        .done      (cpu_done),
        .timed_out (timed_out)
    );

    cbus_rmux u_rmux (
        .active    (active),
        .rg        (cur.rg),
        .timed_out (timed_out),
        .rom_d     (rom_rdata),
        .ram_d     (ram_rdata),
        .ext_d     (data_io),
        .rdata     (cpu_rdata)
    );

    assign cyc       = active;
    assign stb       = active;
    assign sel       = active ? 2'b11 : 2'b00;
    assign rd_n      = !(active && !cur.we);
    assign wr_n      = !(active && cur.we);
    assign bus_addr  = active ? cur.addr : '0;
    assign bus_wdata = (active && cur.we) ? cur.wdata : '0;
    assign rom_cs    = active && (cur.rg == RG_ROM);
    assign ram_cs    = active && (cur.rg == RG_RAM);

    for (genvar g = 0; g < EXT_N; g++) begin : g_ext_sel
        assign ext_cs_n[g] = !(active && (cur.rg == ext_region(g)));
    end

    assign drive   = active && cur.we && is_ext(cur.rg);
    assign data_io = drive ? cur.wdata : {DATA_W{1'bz}};

    assign kind_vec  = active ? (4'b0001 << cur.kind) : 4'b0000;
    assign load_cyc  = kind_vec[K_LOAD];
    assign fetch_cyc = kind_vec[K_FETCH];
    assign const_cyc = kind_vec[K_CONST];
    assign inta_cyc  = kind_vec[K_INTA];

endmodule

// File: rtl/cbus_chk.sv
module cbus_chk #(
    parameter int TIMEOUT_CYC = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cyc,
    input logic        stb,
    input logic [1:0]  sel,
    input logic        rd_n,
    input logic        wr_n,
    input logic        rom_cs,
    input logic        ram_cs,
    input logic [1:0]  ext_cs_n,
    input logic        ext_ack,
    input logic        cpu_done,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata
);
    int unsigned run_cnt;

    always_ff @(posedge clk) begin
        if (rst)                  run_cnt <= 0;
        else if (cyc && !cpu_done) run_cnt <= run_cnt + 1;
        else                      run_cnt <= 0;
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_cs, ram_cs, ~ext_cs_n})); // R1
    AST_SELECT_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (rom_cs || ram_cs || !(&ext_cs_n)) |-> cyc); // R1
    AST_INTERNAL_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (cyc && (rom_cs || ram_cs)) |-> cpu_done); // R3
    AST_DONE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cyc); // R3
    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
        (cyc && !(&ext_cs_n) && ext_ack) |-> cpu_done); // R4
    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_cnt < TIMEOUT_CYC); // R5
    AST_STROBE_FULL: assert property (@(posedge clk) disable iff (rst)
        stb |-> (cyc && sel == 2'b11)); // R6
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc && !cpu_done) |=> (cyc && $stable(bus_addr) && $stable(bus_wdata))); // R11

endmodule

bind cpu_bus_ctrl cbus_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc       (cyc),
    .stb       (stb),
    .sel       (sel),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ext_cs_n  (ext_cs_n),
    .ext_ack   (ext_ack),
    .cpu_done  (cpu_done),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/cpu_bus_ctrl_tb.sv
module cpu_bus_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int TO    = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, ext_ack = 1'b0;
    logic [1:0]  cpu_kind = 2'd0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata, bus_addr, bus_wdata, rom_rdata, ram_rdata;
    logic        cpu_done, rom_cs, ram_cs, cyc, stb, rd_n, wr_n;
    logic        fetch_cyc, load_cyc, const_cyc, inta_cyc;
    logic [1:0]  ext_cs_n, sel;
    wire  [15:0] data_io;

    int vec = 0, bad = 0;
    bit finished = 0;
    logic [15:0] ram_mem [1024];
    logic [15:0] sh_ram  [1024];

    always #(CLK_P/2) clk = ~clk;

    cpu_bus_ctrl #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_kind(cpu_kind),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rom_cs(rom_cs), .ram_cs(ram_cs),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .ext_cs_n(ext_cs_n), .ext_ack(ext_ack),
        .data_io(data_io), .cyc(cyc), .stb(stb), .sel(sel), .rd_n(rd_n), .wr_n(wr_n),
        .fetch_cyc(fetch_cyc), .load_cyc(load_cyc), .const_cyc(const_cyc), .inta_cyc(inta_cyc)
    );

    function automatic logic [15:0] rom_word(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] ext_word(logic [15:0] a);
        return (a * 16'd37) ^ 16'h3C96;
    endfunction

    function automatic int exp_rg(logic [15:0] a);
        if (a >= 16'h2000) return 2;
        if (a >= 16'h1800) return 3;
        if (a >= 16'h1000) return 1;
        if (a <  16'h0800) return 0;
        return 4;
    endfunction

    function automatic logic [3:0] exp_sels(int rg);
        // {rom_cs, ram_cs, ext_cs_n[1], ext_cs_n[0]}
        case (rg)
            0: return 4'b1011;
            1: return 4'b0111;
            2: return 4'b0010;
            3: return 4'b0001;
            default: return 4'b0011;
        endcase
    endfunction

    assign rom_rdata = rom_word(bus_addr);
    assign ram_rdata = ram_mem[bus_addr[10:1]];
    assign data_io   = (!rd_n && !(&ext_cs_n)) ? ext_word(bus_addr) : 16'hzzzz;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) ram_mem[i] <= '0;
        end else if (ram_cs && !wr_n) begin
            ram_mem[bus_addr[10:1]] <= bus_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        vec++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic xfer(input bit we, input logic [1:0] kind, input logic [15:0] addr,
                        input logic [15:0] wd, input int dly, input bit inject);
        int          rg   = exp_rg(addr);
        bit          ext  = (rg == 2) || (rg == 3);
        bit          got  = 0;
        int          nexp;
        logic [15:0] rexp;
        nexp = !ext ? 1 : ((dly >= 1 && dly <= TO) ? dly : TO);
        case (rg)
            0: rexp = rom_word(addr);
            1: rexp = sh_ram[addr[10:1]];
            2, 3: rexp = (dly >= 1 && dly <= TO) ? ext_word(addr) : 16'h0000;
            default: rexp = 16'h0000;
        endcase
        @(negedge clk);
        ext_ack = 0; cpu_req = 1; cpu_we = we; cpu_kind = kind; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        for (int n = 1; n <= TO + 2 && !got; n++) begin
            ext_ack = ext && (dly == n);
            if (inject && n == 2) begin cpu_req = 1; cpu_addr = 16'h0010; end
            if (inject && n == 3) cpu_req = 0;
            #1;
            chk("R11 bus_addr held", bus_addr, addr);
            if (we) chk("R11 bus_wdata held", bus_wdata, wd);
            if (n == 1) begin
                chk("R1 selects", {rom_cs, ram_cs, ext_cs_n}, exp_sels(rg));
                chk("R6 cyc/stb/sel/rd_n/wr_n", {cyc, stb, sel, rd_n, wr_n},
                    {4'b1111, we, !we});
                chk("R7 kind flags", {inta_cyc, const_cyc, fetch_cyc, load_cyc},
                    32'(4'b0001 << kind));
                if (ext && we) chk("R8 data_io carries write data", data_io, wd);
            end
            if (cpu_done) begin
                got = 1;
                if (ext) begin
                    if (dly == TO) chk("R5 ack at timeout cycle: cycles", n, nexp);
                    else if (dly >= 1 && dly < TO) chk("R4 ack cycle count", n, nexp);
                    else chk("R5 timeout cycle count", n, nexp);
                end else begin
                    chk("R3 one-cycle completion", n, nexp);
                end
                if (!we) begin
                    if (ext) chk("R4/R5 external read data (R8 bus released)", cpu_rdata, rexp);
                    else     chk("R2 read data", cpu_rdata, rexp);
                end
            end else begin
                @(negedge clk);
            end
        end
        if (!got) chk("R3 transfer never completed", 0, 1);
        if (we && rg == 1) sh_ram[addr[10:1]] = wd;
        if (inject) begin
            @(negedge clk);
            #1;
            chk("R9 start pulse while busy ignored", {cyc, rd_n, wr_n}, 3'b011);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) sh_ram[i] = '0;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R10 reset outputs",
            {cyc, stb, sel, rd_n, wr_n, rom_cs, ram_cs, ext_cs_n, cpu_done,
             fetch_cyc, load_cyc, const_cyc, inta_cyc},
            {2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 1'b0, 4'b0000});

        xfer(0, 2'd1, 16'h0124, 16'h0, 0, 0);   // ROM fetch
        xfer(1, 2'd0, 16'h1000, 16'hBEEF, 0, 0);// RAM low edge write
        xfer(0, 2'd0, 16'h1000, 16'h0, 0, 0);
        xfer(1, 2'd0, 16'h17FE, 16'h1234, 0, 0);// RAM top word
        xfer(0, 2'd2, 16'h17FE, 16'h0, 0, 0);
        xfer(0, 2'd0, 16'h0800, 16'h0, 0, 0);   // unmapped low edge
        xfer(0, 2'd0, 16'h0FFF, 16'h0, 0, 0);   // unmapped high edge
        xfer(1, 2'd0, 16'h07FE, 16'hAAAA, 0, 0);// ROM write, no effect
        xfer(0, 2'd0, 16'h07FE, 16'h0, 0, 0);
        xfer(0, 2'd0, 16'h2000, 16'h0, 1, 0);   // ext0 boundary
        xfer(0, 2'd0, 16'h1FFF, 16'h0, 3, 0);   // ext1 top
        xfer(0, 2'd0, 16'h1800, 16'h0, 2, 0);   // ext1 low edge
        xfer(0, 2'd3, 16'hFFFE, 16'h0, 0, 0);   // timeout, inta tag
        xfer(0, 2'd0, 16'h4000, 16'h0, TO, 0);  // ack on timeout cycle
        xfer(0, 2'd0, 16'h4002, 16'h0, TO - 1, 0);
        xfer(1, 2'd0, 16'h2100, 16'hC0DE, 2, 0);// ext write
        xfer(1, 2'd0, 16'h1900, 16'h5A5A, 0, 0);// ext write timeout
        xfer(0, 2'd0, 16'h3000, 16'h0, 6, 1);   // busy injection

        for (int t = 0; t < 400; t++) begin
            int          r = int'($urandom % 5);
            logic [15:0] a;
            case (r)
                0: a = 16'($urandom % 2048);
                1: a = 16'h1000 + 16'($urandom % 2048);
                2: a = 16'h2000 + 16'($urandom % 32'hE000);
                3: a = 16'h1800 + 16'($urandom % 2048);
                default: a = 16'h0800 + 16'($urandom % 2048);
            endcase
            xfer(1'($urandom), 2'($urandom), a, 16'($urandom),
                 int'($urandom % (TO + 3)), 0);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            finished = 1;
            vec++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule